// File: doc/BRIEF.md
# Aligned Vector Move Decoder

This block decodes one aligned packed-integer vector move instruction from a window of up to eight instruction bytes. Byte 0 of the window sits in bits [7:0], byte 1 in bits [15:8], and so on. Two encodings are accepted. The first is a legacy form: an operand-size byte 0x66, an optional register-extension byte in 64-bit mode, the escape 0x0F, the opcode and an operand-selector byte. The second is a compact vector prefix, in a two-byte (0xC5) or three-byte (0xC4) variant, followed by the opcode and the operand-selector byte.

For each window presented with the valid strobe, the block registers a decoded result one cycle later. The result holds:
- the move direction;
- the vector width;
- the full register index;
- the addressing mode field and whether the second operand is a register;
- the second operand's index;
- whether the destination's upper bits are preserved or zeroed;
- the total instruction length, so a fetch unit can advance.

It separates two kinds of failure. An "undefined" fault covers a vector-prefix encoding whose unused register field is wrong. "Unrecognized" covers anything that is not this instruction at all. Address arithmetic is left to a later stage.

Top module: `avec_move_decode`

## Requirements
- R1: In the legacy form (0x66, optional extension byte, 0x0F, opcode, selector), opcode 0x6F decodes as a load (store_o=0: the selector's reg field names the destination) and 0x7F as a store (store_o=1: the reg field names the source).
- R2: A legacy-form result is always 128 bits wide (wide_o=0), marks the destination upper bits as preserved (zero_upper_o=0) and never raises undef_o.
- R3: The two-byte vector prefix 0xC5 is followed by a byte laid out as {inverted R [7], vvvv [6:3], L [2], pp [1:0]}. It requires pp=2'b01 and implies the 0x0F map. The opcode byte and then the selector byte follow. L gives wide_o, and zero_upper_o=1.
- R4: The three-byte vector prefix 0xC4 is followed by {inverted R [7], inverted X [6], inverted B [5], map [4:0]} and then {W [7], vvvv [6:3], L [2], pp [1:0]}. It requires map=5'b00001 and pp=2'b01, and W has no effect on any output. zero_upper_o=1.
- R5: In either vector prefix, the raw vvvv bits must be 4'b1111. Any other value sets undef_o=1, and every other field is still decoded.
- R6: In 64-bit mode, the extension bits are used as follows. A legacy extension byte 0x40-0x4F between 0x66 and 0x0F supplies reg_idx_o[3] from its bit 2 and rm_idx_o[3] from its bit 0. In the vector prefixes, the complement of the stored R bit supplies reg_idx_o[3], and for 0xC4 the complement of the stored B bit supplies rm_idx_o[3]. Outside 64-bit mode, reg_idx_o[3] and rm_idx_o[3] are 0.
- R7: Outside 64-bit mode, two windows are unrecognized. One is 0xC4 or 0xC5 whose next byte has bits [7:6] other than 2'b11. The other is a 0x4x byte after 0x66.
- R8: These windows give unrec_o=1 and undef_o=0, with every other field and len_o equal to zero:
  - an opcode other than 0x6F/0x7F;
  - a missing 0x0F escape;
  - a vector map other than 5'b00001;
  - pp other than 2'b01;
  - a leading byte that is none of 0x66/0xC4/0xC5.
- R9: mod_o carries selector bits [7:6], reg_idx_o[2:0] carries bits [5:3], and rm_idx_o[2:0] carries bits [2:0]. rm_is_reg_o=1 exactly when mod is 2'b11.
- R10: len_o counts every byte through the selector, plus a scale-index byte when mod!=3 and rm=4, plus displacement bytes:
  - mod=1 adds 1;
  - mod=2 adds 4;
  - mod=0 adds 4 when rm=5, or when rm=4 and the scale-index byte's bits [2:0] equal 5.
- R11: A result appears one cycle after the window is accepted. A cycle with valid_i low gives out_valid_o=0 on the next cycle and leaves every other output unchanged.
- R12: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Window holds an instruction to decode |
| mode64_i | input | 1 | Core runs in 64-bit mode |
| win_i | input | 64 | Instruction bytes, byte 0 in bits [7:0] |
| out_valid_o | output | 1 | Registered result is present |
| store_o | output | 1 | 1 = register to r/m, 0 = r/m to register |
| wide_o | output | 1 | 1 = 256-bit, 0 = 128-bit |
| zero_upper_o | output | 1 | 1 = destination bits above the width are cleared |
| reg_idx_o | output | 4 | Register named by the reg field |
| rm_is_reg_o | output | 1 | Second operand is a register |
| mod_o | output | 2 | Addressing mode field |
| rm_idx_o | output | 4 | r/m field with its extension bit |
| undef_o | output | 1 | Undefined-opcode fault (bad vvvv) |
| unrec_o | output | 1 | Window is not this instruction |
| len_o | output | 4 | Instruction length in bytes |

## Verification
All results leave a single register stage. Every output for a window driven on a falling edge is due right after the following rising edge. The bench drives each window on a falling edge and compares the whole output word on the next falling edge, so every sample lands mid-cycle and exactly one register later. Idle cycles are checked the same way: one falling edge after valid_i drops, the bench expects out_valid_o low and every field equal to the previous result.

// File: rtl/avm_pkg.sv
package avm_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_W    = 4;
    localparam int LEN_W    = 4;
    localparam int IDX_W    = 3;

    localparam logic [7:0] B_OPSIZE   = 8'h66;
    localparam logic [7:0] B_ESCAPE   = 8'h0F;
    localparam logic [7:0] B_VPFX2    = 8'hC5;
    localparam logic [7:0] B_VPFX3    = 8'hC4;
    localparam logic [7:0] B_OP_LOAD  = 8'h6F;
    localparam logic [7:0] B_OP_STORE = 8'h7F;
    localparam logic [4:0] MAP_0F     = 5'b00001;
    localparam logic [1:0] PP_OPSIZE  = 2'b01;
    localparam logic [3:0] VV_UNUSED  = 4'b1111;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_LEGACY = 2'd1,
        FORM_VPFX2  = 2'd2,
        FORM_VPFX3  = 2'd3
    } form_e;

    typedef struct packed {
        logic             vld;
        logic             store;
        logic             wide;
        logic             zero_upper;
        logic [REG_W-1:0] reg_idx;
        logic             rm_is_reg;
        logic [1:0]       mod;
        logic [REG_W-1:0] rm_idx;
        logic             undef;
        logic             unrec;
        logic [LEN_W-1:0] len;
    } dec_s;

endpackage

// File: rtl/avm_hdr_scan.sv
module avm_hdr_scan
    import avm_pkg::*;
#(
    parameter int WIN_BYTES = 8
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
    input  logic                        mode64_i,
    output form_e                       form_o,
    output logic [LEN_W-1:0]            hdr_len_o,
    output logic                        ext_r_o,
    output logic                        ext_b_o,
    output logic [3:0]                  vv_raw_o,
    output logic                        wide_o,
    output logic                        hdr_ok_o
);

    logic [BYTE_W-1:0] byt [WIN_BYTES];

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_unpack
        assign byt[g] = win_i[g*BYTE_W +: BYTE_W];
    end

    logic short_ok;
    assign short_ok = mode64_i || (byt[1][7:6] == 2'b11);

    always_comb begin
        form_o    = FORM_NONE;
        hdr_len_o = '0;
        ext_r_o   = 1'b0;
        ext_b_o   = 1'b0;
        vv_raw_o  = VV_UNUSED;
        wide_o    = 1'b0;
        hdr_ok_o  = 1'b0;
        if (byt[0] == B_OPSIZE) begin
            form_o = FORM_LEGACY;
            if (mode64_i && byt[1][7:4] == 4'h4) begin
                hdr_len_o = LEN_W'(5);
                ext_r_o   = byt[1][2];
                ext_b_o   = byt[1][0];
                hdr_ok_o  = (byt[2] == B_ESCAPE);
            end else begin
                hdr_len_o = LEN_W'(4);
                hdr_ok_o  = (byt[1] == B_ESCAPE);
            end
        end else if (byt[0] == B_VPFX2 && short_ok) begin
            form_o    = FORM_VPFX2;
            hdr_len_o = LEN_W'(4);
            ext_r_o   = mode64_i & ~byt[1][7];
            vv_raw_o  = byt[1][6:3];
            wide_o    = byt[1][2];
            hdr_ok_o  = (byt[1][1:0] == PP_OPSIZE);
        end else if (byt[0] == B_VPFX3 && short_ok) begin
            form_o    = FORM_VPFX3;
            hdr_len_o = LEN_W'(5);
            ext_r_o   = mode64_i & ~byt[1][7];
            ext_b_o   = mode64_i & ~byt[1][5];
            vv_raw_o  = byt[2][6:3];
            wide_o    = byt[2][2];
            hdr_ok_o  = (byt[1][4:0] == MAP_0F) && (byt[2][1:0] == PP_OPSIZE);
        end
    end

endmodule

// File: rtl/avm_opnd_len.sv
module avm_opnd_len
    import avm_pkg::*;
(
    input  logic [BYTE_W-1:0] sel_i,
    input  logic [BYTE_W-1:0] sib_i,
    output logic [2:0]        extra_o,
    output logic              rm_is_reg_o
);

    logic [1:0] mode;
    logic [2:0] rm;
    assign mode = sel_i[7:6];
    assign rm   = sel_i[2:0];

    always_comb begin
        extra_o     = 3'd0;
        rm_is_reg_o = (mode == 2'b11);
        if (!rm_is_reg_o) begin
            if (rm == 3'd4) begin
                extra_o = 3'd1;
                if (mode == 2'b00 && sib_i[2:0] == 3'd5) extra_o = extra_o + 3'd4;
            end else if (mode == 2'b00 && rm == 3'd5) begin
                extra_o = 3'd4;
            end
            if (mode == 2'b01) extra_o = extra_o + 3'd1;
            if (mode == 2'b10) extra_o = extra_o + 3'd4;
        end
    end

endmodule

// File: rtl/avec_move_decode.sv
module avec_move_decode
    import avm_pkg::*;
#(
    parameter int WIN_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid_i,
    input  logic                        mode64_i,
    input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
    output logic                        out_valid_o,
    output logic                        store_o,
    output logic                        wide_o,
    output logic                        zero_upper_o,
    output logic [REG_W-1:0]            reg_idx_o,
    output logic                        rm_is_reg_o,
    output logic [1:0]                  mod_o,
    output logic [REG_W-1:0]            rm_idx_o,
    output logic                        undef_o,
    output logic                        unrec_o,
    output logic [LEN_W-1:0]            len_o
);

    form_e             form;
    logic [LEN_W-1:0]  hdr_len;
    logic              ext_r, ext_b, hdr_wide, hdr_ok;
    logic [3:0]        vv_raw;

    avm_hdr_scan #(.WIN_BYTES(WIN_BYTES)) u_hdr (
        .win_i     (win_i),
        .mode64_i  (mode64_i),
        .form_o    (form),
        .hdr_len_o (hdr_len),
        .ext_r_o   (ext_r),
        .ext_b_o   (ext_b),
        .vv_raw_o  (vv_raw),
        .wide_o    (hdr_wide),
        .hdr_ok_o  (hdr_ok)
    );

    // opcode sits two bytes before the header end, selector one byte before
    logic [IDX_W-1:0]  op_pos, sel_pos, sib_pos;
    logic [BYTE_W-1:0] op_byte, sel_byte, sib_byte;
    assign op_pos   = hdr_len[IDX_W-1:0] - IDX_W'(2);
    assign sel_pos  = hdr_len[IDX_W-1:0] - IDX_W'(1);
    assign sib_pos  = hdr_len[IDX_W-1:0];
    assign op_byte  = win_i[op_pos  * BYTE_W +: BYTE_W];
    assign sel_byte = win_i[sel_pos * BYTE_W +: BYTE_W];
    assign sib_byte = win_i[sib_pos * BYTE_W +: BYTE_W];

    logic [2:0] extra;
    logic       sel_reg;

    avm_opnd_len u_len (
        .sel_i       (sel_byte),
        .sib_i       (sib_byte),
        .extra_o     (extra),
        .rm_is_reg_o (sel_reg)
    );

    logic known;
    assign known = (form != FORM_NONE) && hdr_ok &&
                   (op_byte == B_OP_LOAD || op_byte == B_OP_STORE);

    dec_s dec_d, dec_q;

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = valid_i;
        if (valid_i) begin
            dec_d     = '0;
            dec_d.vld = 1'b1;
            if (!known) begin
                dec_d.unrec = 1'b1;
            end else begin
                dec_d.store      = (op_byte == B_OP_STORE);
                dec_d.wide       = hdr_wide;
                dec_d.zero_upper = (form != FORM_LEGACY);
                dec_d.reg_idx    = {ext_r, sel_byte[5:3]};
                dec_d.rm_idx     = {ext_b, sel_byte[2:0]};
                dec_d.mod        = sel_byte[7:6];
                dec_d.rm_is_reg  = sel_reg;
                dec_d.undef      = (form != FORM_LEGACY) && (vv_raw != VV_UNUSED);
                dec_d.len        = hdr_len + LEN_W'(extra);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid_o  = dec_q.vld;
    assign store_o      = dec_q.store;
    assign wide_o       = dec_q.wide;
    assign zero_upper_o = dec_q.zero_upper;
    assign reg_idx_o    = dec_q.reg_idx;
    assign rm_is_reg_o  = dec_q.rm_is_reg;
    assign mod_o        = dec_q.mod;
    assign rm_idx_o     = dec_q.rm_idx;
    assign undef_o      = dec_q.undef;
    assign unrec_o      = dec_q.unrec;
    assign len_o        = dec_q.len;

    p_unrec_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && unrec_o) |-> (!undef_o && len_o == '0 && reg_idx_o == '0 && !store_o));

    p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !unrec_o) |-> (len_o >= LEN_W'(4) && len_o <= LEN_W'(10)));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !out_valid_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(reg_idx_o) && $stable(len_o) && $stable(rm_idx_o)));

    p_legacy_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !unrec_o && !zero_upper_o) |-> (!wide_o && !undef_o));

    p_reg_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && rm_is_reg_o) |-> (mod_o == 2'b11 && len_o <= LEN_W'(5)));

    p_no_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mode64_i) |=> (!reg_idx_o[3] && !rm_idx_o[3]));

endmodule

// File: tb/tb_avec_move_decode.sv
module tb_avec_move_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        mode64_i = 1'b0;
    logic [63:0] win_i = '0;
    logic        out_valid_o, store_o, wide_o, zero_upper_o, rm_is_reg_o, undef_o, unrec_o;
    logic [3:0]  reg_idx_o, rm_idx_o, len_o;
    logic [1:0]  mod_o;

    avec_move_decode dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode64_i(mode64_i), .win_i(win_i),
        .out_valid_o(out_valid_o), .store_o(store_o), .wide_o(wide_o),
        .zero_upper_o(zero_upper_o), .reg_idx_o(reg_idx_o), .rm_is_reg_o(rm_is_reg_o),
        .mod_o(mod_o), .rm_idx_o(rm_idx_o), .undef_o(undef_o), .unrec_o(unrec_o),
        .len_o(len_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    logic [20:0] last_exp = '0;

    localparam logic [20:0] EXP_UNREC = 21'h100010;

    function automatic logic [20:0] mk(input logic st, input logic wd, input logic zu,
                                       input logic [3:0] rg, input logic [1:0] md,
                                       input logic [3:0] rm, input logic ud,
                                       input logic [3:0] ln);
        return {1'b1, st, wd, zu, rg, (md == 2'b11), md, rm, ud, 1'b0, ln};
    endfunction

    task automatic check(input logic [20:0] exp, input string tag);
        logic [20:0] act;
        act = {out_valid_o, store_o, wide_o, zero_upper_o, reg_idx_o, rm_is_reg_o,
               mod_o, rm_idx_o, undef_o, unrec_o, len_o};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] w, input logic m64,
                         input logic [20:0] exp, input string tag);
        valid_i  = 1'b1;
        win_i    = w;
        mode64_i = m64;
        @(negedge clk);
        check(exp, tag);
        last_exp = exp;
    endtask

    task automatic idle(input string tag);
        valid_i = 1'b0;
        win_i   = {$urandom, $urandom};
        @(negedge clk);
        check({1'b0, last_exp[19:0]}, tag);
        last_exp = {1'b0, last_exp[19:0]};
    endtask

    // form: 0 legacy, 1 two-byte prefix, 2 three-byte prefix
    task automatic build(input int form, input logic m64, input logic use_ext,
                         input logic st, input logic lw, input logic [3:0] rg,
                         input logic [3:0] rm, input logic [1:0] md,
                         input logic [3:0] vv, input logic wb,
                         output logic [63:0] w, output logic [20:0] exp);
        logic [7:0] by [8];
        logic [7:0] op;
        logic [7:0] sel;
        logic [3:0] erg, erm;
        logic [3:0] base;
        logic [3:0] ln;
        logic       rs, bs;
        for (int i = 0; i < 8; i++) by[i] = 8'($urandom);
        op  = st ? 8'h7F : 8'h6F;
        sel = {md, rg[2:0], rm[2:0]};
        erg = {1'b0, rg[2:0]};
        erm = {1'b0, rm[2:0]};
        if (form == 0) begin
            by[0] = 8'h66;
            if (use_ext) begin
                by[1] = {4'h4, wb, rg[3], 1'b0, rm[3]};
                by[2] = 8'h0F; by[3] = op; by[4] = sel; base = 4'd5;
                erg = rg; erm = rm;
            end else begin
                by[1] = 8'h0F; by[2] = op; by[3] = sel; base = 4'd4;
            end
        end else if (form == 1) begin
            rs = m64 ? ~rg[3] : 1'b1;
            by[0] = 8'hC5; by[1] = {rs, vv, lw, 2'b01}; by[2] = op; by[3] = sel;
            base = 4'd4;
            if (m64) erg = rg;
        end else begin
            rs = m64 ? ~rg[3] : 1'b1;
            bs = m64 ? ~rm[3] : 1'($urandom);
            by[0] = 8'hC4; by[1] = {rs, 1'b1, bs, 5'b00001};
            by[2] = {wb, vv, lw, 2'b01}; by[3] = op; by[4] = sel;
            base = 4'd5;
            if (m64) begin erg = rg; erm = rm; end
        end
        ln = base;
        if (md != 2'b11) begin
            if (rm[2:0] == 3'd4) begin
                ln = ln + 4'd1;
                if (md == 2'b00 && by[base[2:0]][2:0] == 3'd5) ln = ln + 4'd4;
            end else if (md == 2'b00 && rm[2:0] == 3'd5) begin
                ln = ln + 4'd4;
            end
            if (md == 2'b01) ln = ln + 4'd1;
            if (md == 2'b10) ln = ln + 4'd4;
        end
        for (int i = 0; i < 8; i++) w[i*8 +: 8] = by[i];
        exp = mk(st, (form != 0) && lw, form != 0, erg, md, erm,
                 (form != 0) && (vv != 4'hF), ln);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [63:0] w;
        logic [20:0] e;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(21'h0, "R12 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(21'h0, "R12 idle after reset");

        // R1 legacy load / store, register form
        apply(64'h00000000C06F0F66, 1'b0, mk(0, 0, 0, 4'd0, 2'b11, 4'd0, 0, 4'd4), "R1 R2 load");
        apply(64'h00000000D17F0F66, 1'b0, mk(1, 0, 0, 4'd2, 2'b11, 4'd1, 0, 4'd4), "R1 R2 store");
        idle("R11 hold after store");
        // R6 legacy extension byte in 64-bit mode
        apply(64'h000000C86F0F4566, 1'b1, mk(0, 0, 0, 4'd9, 2'b11, 4'd8, 0, 4'd5), "R6 legacy extension");
        // R7 0x4x after 0x66 outside 64-bit mode
        apply(64'h000000C86F0F4566, 1'b0, EXP_UNREC, "R7 extension outside 64-bit");
        // R8 unrecognized cases
        apply(64'h00000000C06E0F66, 1'b1, EXP_UNREC, "R8 bad opcode");
        apply(64'h00000000C06F0E66, 1'b1, EXP_UNREC, "R8 missing escape");
        apply(64'h00000000C06FF8C5, 1'b1, EXP_UNREC, "R8 pp not 01");
        apply(64'h000000C06F79E2C4, 1'b1, EXP_UNREC, "R8 map not 0F");
        apply(64'h00000000C06F0F90, 1'b1, EXP_UNREC, "R8 unknown lead byte");
        // R7 short-prefix bytes with top bits not 11 outside 64-bit mode
        apply(64'h00000000C06F79C5, 1'b0, EXP_UNREC, "R7 short prefix outside 64-bit");
        apply(64'h00000000C06F79C5, 1'b1, mk(0, 0, 1, 4'd8, 2'b11, 4'd0, 0, 4'd4), "R3 R6 inverted R");
        // R4 W ignored, L selects width
        apply(64'h000000C06F79E1C4, 1'b0, mk(0, 0, 1, 4'd0, 2'b11, 4'd0, 0, 4'd5), "R4 W clear");
        apply(64'h000000C06FF9E1C4, 1'b0, mk(0, 0, 1, 4'd0, 2'b11, 4'd0, 0, 4'd5), "R4 W set ignored");
        apply(64'h000000C07F7DE1C4, 1'b0, mk(1, 1, 1, 4'd0, 2'b11, 4'd0, 0, 4'd5), "R4 L wide store");
        // R5 bad vvvv
        apply(64'h00000000C06FB9C5, 1'b1, mk(0, 0, 1, 4'd0, 2'b11, 4'd0, 1, 4'd4), "R5 vvvv not ones");
        // R10 length corners: sib with no-base disp32, rip-style disp32, disp8
        apply(64'h0000000D046F0F66, 1'b0, mk(0, 0, 0, 4'd0, 2'b00, 4'd4, 0, 4'd9), "R10 sib disp32");
        apply(64'h00000000056F0F66, 1'b0, mk(0, 0, 0, 4'd0, 2'b00, 4'd5, 0, 4'd8), "R10 rm5 disp32");
        apply(64'h000024847F0F4C66, 1'b1, mk(1, 0, 0, 4'd8, 2'b10, 4'd4, 0, 4'd10), "R9 R10 sib disp32 max");
        idle("R11 hold after length");

        for (int n = 0; n < 400; n++) begin
            int         form;
            logic       m64, ue;
            logic [3:0] vv;
            string      tag;
            form = int'($urandom % 3);
            m64  = 1'($urandom);
            ue   = m64 & 1'($urandom);
            vv   = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            if (form == 1 && !m64) vv[3] = 1'b1;
            build(form, m64, ue, 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
                  2'($urandom), vv, 1'($urandom), w, e);
            tag = (form == 0) ? "R1 R2 R6 R9 R10 random legacy" :
                  (form == 1) ? "R3 R5 R6 R9 R10 random short prefix" :
                                "R4 R5 R6 R9 R10 random long prefix";
            apply(w, m64, e, tag);
            if ($urandom % 8 == 0) idle("R11 random idle");
        end

        valid_i = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule